// File: doc/BRIEF.md
# Window Watchdog with Wake-Up Supervision

This block watches a processor through two signals: a trigger line and a mode line. In the short period, the processor must pull the trigger low inside an open window. That window opens only after a closed time and ends at a timeout. A trigger that comes too early, or no trigger at all, starts a fixed-length active-low reset pulse. After three correct triggers in a row, an enable output goes active to switch on peripheral parts. Any reset pulse clears that count.

If the mode line is high when a correct trigger arrives, the next period is a long one. Its length is a base count shifted left by a time-select input. During the long period triggers are ignored. The period ends either when mode falls, which returns the block to the short period, or when it times out, which starts a reset pulse.

Six wake-up inputs each pass through a digital stability filter. During the long period, any rising or falling edge of a filtered wake-up level also starts a reset pulse. All timing is counted in cycles of one clock.

Top module: `winwdt_top`

## Requirements
- R1: While `rst_i` is high, `rst_n_o` is 0 and `en_o` is 0. After `rst_i` falls, the block runs a reset pulse.
- R2: In the short period, a trigger falling edge (`trig_i` 1 on the previous cycle, 0 now) with fewer than CLOSED_CYC cycles elapsed starts a reset pulse on the next cycle.
- R3: In the short period, if no falling edge arrives by the cycle with CLOSED_CYC+OPEN_CYC-1 cycles elapsed, a reset pulse starts on the next cycle.
- R4: In the short period, a falling edge with between CLOSED_CYC and CLOSED_CYC+OPEN_CYC-1 cycles elapsed is correct. It restarts the period count from 0 and keeps `rst_n_o` high.
- R5: `en_o` goes to 1 on the cycle after the third correct trigger since the last reset pulse, and then stays at 1.
- R6: When a reset pulse begins, `en_o` goes to 0 on the same cycle and the correct-trigger count is cleared. Three new correct triggers are needed before `en_o` returns.
- R7: A reset pulse holds `rst_n_o` at 0 for exactly PULSE_CYC cycles. The short period then starts with a count of 0.
- R8: A correct trigger that arrives while `mode_i` is 1 starts a long period of LONG_BASE << `tsel_i` cycles. Triggers are ignored during it. If the long period reaches its end, a reset pulse starts.
- R9: During the long period, if `mode_i` is 0 (and neither a wake-up edge nor the timeout occurs), the block returns to the short period with a count of 0.
- R10: During the long period, a rising or falling edge on any filtered wake-up level starts a reset pulse. During the short period, wake-up edges have no effect.
- R11: A wake-up input takes a new filtered level only after differing from the current filtered level for DEB_CYC consecutive cycles. Shorter excursions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| trig_i | input | 1 | Processor trigger; the falling edge counts |
| mode_i | input | 1 | 1 requests the long period |
| tsel_i | input | TSEL_W | Long-period length select (shift amount) |
| wake_i | input | N_WAKE | Raw wake-up inputs |
| rst_n_o | output | 1 | Active-low reset to the processor |
| en_o | output | 1 | Peripheral enable |

## Verification
The bench builds the block with CLOSED_CYC=8, OPEN_CYC=8, PULSE_CYC=5, DEB_CYC=3 and LONG_BASE=32. With these values, early, in-window and missing triggers, and timeouts of the long period at both tsel values 0 and 1, all fit in a short run. A debounce depth of 3 lets a two-cycle glitch be told apart from a held level. The small pulse length makes the restart in the short period visible cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        PH_PULSE = 2'd0,
        PH_SHORT = 2'd1,
        PH_LONG  = 2'd2
    } wdt_phase_e;

    localparam int GOOD_NEEDED = 3;
    localparam int GOOD_W      = 2;
endpackage

// File: rtl/wdt_debounce.sv
module wdt_debounce #(
    parameter int DEB_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    output logic edge_o
);
    localparam int DW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          filt;
        logic          prev;
    } deb_t;

    deb_t q, d;

    always_comb begin
        d      = q;
        d.prev = q.filt;
        if (raw_i == q.filt) begin
            d.cnt = '0;
        end else if (q.cnt == DW'(DEB_CYC - 1)) begin
            d.filt = raw_i;
            d.cnt  = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign edge_o = q.filt ^ q.prev;

    // R11: the filtered level cannot move before the stability count is reached
    p_stable_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.cnt != DW'(DEB_CYC - 1)) |=> $stable(q.filt));
endmodule

// File: rtl/wdt_window.sv
module wdt_window
    import wdt_pkg::*;
#(
    parameter int CLOSED_CYC = 16,
    parameter int OPEN_CYC   = 16,
    parameter int LONG_BASE  = 64,
    parameter int TSEL_W     = 2,
    parameter int PULSE_CYC  = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              trig_i,
    input  logic              mode_i,
    input  logic [TSEL_W-1:0] tsel_i,
    input  logic              wake_edge_i,
    output logic              rst_n_o,
    output logic              en_o
);
    localparam int LONG_MAX = LONG_BASE << ((1 << TSEL_W) - 1);
    localparam int SHORT_END = CLOSED_CYC + OPEN_CYC;
    localparam int TMAX0 = (LONG_MAX > SHORT_END) ? LONG_MAX : SHORT_END;
    localparam int TMAX = (TMAX0 > PULSE_CYC) ? TMAX0 : PULSE_CYC;
    localparam int TW = $clog2(TMAX + 1);

    typedef struct packed {
        wdt_phase_e        phase;
        logic [TW-1:0]     timer;
        logic [GOOD_W-1:0] good;
        logic              trig_prev;
    } win_t;

    win_t q, d;
    logic          fall;
    logic [TW-1:0] long_last;

    assign fall      = q.trig_prev & ~trig_i;
    assign long_last = (TW'(LONG_BASE) << tsel_i) - 1'b1;

    always_comb begin
        d           = q;
        d.trig_prev = trig_i;
        d.timer     = q.timer + 1'b1;
        case (q.phase)
            PH_PULSE: begin
                d.good = '0;
                if (q.timer == TW'(PULSE_CYC - 1)) begin
                    d.phase = PH_SHORT;
                    d.timer = '0;
                end
            end
            PH_SHORT: begin
                if (fall) begin
                    d.timer = '0;
                    if (q.timer < TW'(CLOSED_CYC)) begin
                        d.phase = PH_PULSE;
                        d.good  = '0;
                    end else begin
                        if (q.good != GOOD_W'(GOOD_NEEDED)) d.good = q.good + 1'b1;
                        d.phase = mode_i ? PH_LONG : PH_SHORT;
                    end
                end else if (q.timer == TW'(SHORT_END - 1)) begin
                    d.phase = PH_PULSE;
                    d.timer = '0;
                    d.good  = '0;
                end
            end
            PH_LONG: begin
                if (wake_edge_i || q.timer == long_last) begin
                    d.phase = PH_PULSE;
                    d.timer = '0;
                    d.good  = '0;
                end else if (!mode_i) begin
                    d.phase = PH_SHORT;
                    d.timer = '0;
                end
            end
            default: begin
                d.phase = PH_PULSE;
                d.timer = '0;
                d.good  = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q.phase     <= PH_PULSE;
            q.timer     <= '0;
            q.good      <= '0;
            q.trig_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rst_n_o = (q.phase != PH_PULSE);
    assign en_o    = (q.good == GOOD_W'(GOOD_NEEDED));

    // R2: early trigger leads to a pulse
    p_early_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.phase == PH_SHORT && fall && q.timer < TW'(CLOSED_CYC)) |=> !rst_n_o);
    // R3: timeout in the short period leads to a pulse
    p_timeout_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.phase == PH_SHORT && !fall && q.timer == TW'(SHORT_END - 1)) |=> !rst_n_o);
    // R6: enable never coexists with an active reset
    p_en_off_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_n_o |-> !en_o);
    // R7: pulse ends into a fresh short period
    p_pulse_end_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.phase == PH_PULSE && q.timer == TW'(PULSE_CYC - 1)) |=> (rst_n_o && q.timer == '0));
    // R10: wake edge in the long period forces reset
    p_wake_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.phase == PH_LONG && wake_edge_i) |=> !rst_n_o);
endmodule

// File: rtl/winwdt_top.sv
module winwdt_top #(
    parameter int N_WAKE     = 6,
    parameter int DEB_CYC    = 4,
    parameter int CLOSED_CYC = 16,
    parameter int OPEN_CYC   = 16,
    parameter int LONG_BASE  = 64,
    parameter int TSEL_W     = 2,
    parameter int PULSE_CYC  = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              trig_i,
    input  logic              mode_i,
    input  logic [TSEL_W-1:0] tsel_i,
    input  logic [N_WAKE-1:0] wake_i,
    output logic              rst_n_o,
    output logic              en_o
);
    logic [N_WAKE-1:0] edges;

    for (genvar g = 0; g < N_WAKE; g++) begin : g_deb
        wdt_debounce #(.DEB_CYC(DEB_CYC)) i_deb (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .raw_i  (wake_i[g]),
            .edge_o (edges[g])
        );
    end

    wdt_window #(
        .CLOSED_CYC (CLOSED_CYC),
        .OPEN_CYC   (OPEN_CYC),
        .LONG_BASE  (LONG_BASE),
        .TSEL_W     (TSEL_W),
        .PULSE_CYC  (PULSE_CYC)
    ) i_win (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .trig_i      (trig_i),
        .mode_i      (mode_i),
        .tsel_i      (tsel_i),
        .wake_edge_i (|edges),
        .rst_n_o     (rst_n_o),
        .en_o        (en_o)
    );

    // R1: reset output active during power-on reset
    p_por_r1: assert property (@(posedge clk_i) rst_i |=> (!rst_n_o && !en_o));
endmodule

// File: tb/test_winwdt_top.sv
module test_winwdt_top;
    localparam int NW = 6, DEB = 3, CW = 8, OW = 8, LB = 32, TSW = 2, PC = 5;

    logic clk = 0, rst = 1, trig = 1, mode = 0;
    logic [TSW-1:0] tsel = '0;
    logic [NW-1:0]  wake = '0;
    logic rst_n, en;

    always #5 clk = ~clk;

    winwdt_top #(.N_WAKE(NW), .DEB_CYC(DEB), .CLOSED_CYC(CW), .OPEN_CYC(OW),
                 .LONG_BASE(LB), .TSEL_W(TSW), .PULSE_CYC(PC)) i_winwdt_top (
        .clk_i(clk), .rst_i(rst), .trig_i(trig), .mode_i(mode), .tsel_i(tsel),
        .wake_i(wake), .rst_n_o(rst_n), .en_o(en));

    int vectors = 0, errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference: 0 pulse, 1 short, 2 long
    int m_phase = 0, m_timer = 0, m_good = 0, m_tprev = 1;
    int m_filt[NW], m_prev[NW], m_cnt[NW];

    always @(posedge clk) begin
        bit w, f;
        if (rst) begin
            m_phase = 0; m_timer = 0; m_good = 0; m_tprev = 1;
            for (int i = 0; i < NW; i++) begin m_filt[i] = 0; m_prev[i] = 0; m_cnt[i] = 0; end
        end else begin
            w = 0;
            for (int i = 0; i < NW; i++) if (m_filt[i] != m_prev[i]) w = 1;
            f = (m_tprev == 1) && (trig == 0);
            m_timer++;
            if (m_phase == 0) begin
                m_good = 0;
                if (m_timer == PC) begin m_phase = 1; m_timer = 0; end
            end else if (m_phase == 1) begin
                if (f) begin
                    if (m_timer - 1 < CW) begin m_phase = 0; m_good = 0; end
                    else begin
                        if (m_good < 3) m_good++;
                        m_phase = mode ? 2 : 1;
                    end
                    m_timer = 0;
                end else if (m_timer == CW + OW) begin
                    m_phase = 0; m_timer = 0; m_good = 0;
                end
            end else begin
                if (w || m_timer == (LB << tsel)) begin
                    m_phase = 0; m_timer = 0; m_good = 0;
                end else if (!mode) begin
                    m_phase = 1; m_timer = 0;
                end
            end
            m_tprev = trig;
            for (int i = 0; i < NW; i++) begin
                m_prev[i] = m_filt[i];
                if (int'(wake[i]) == m_filt[i]) m_cnt[i] = 0;
                else if (m_cnt[i] == DEB - 1) begin m_filt[i] = wake[i]; m_cnt[i] = 0; end
                else m_cnt[i]++;
            end
        end
    end

    // every-cycle comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (rst_n !== (m_phase != 0) || en !== (m_good == 3)) begin
                errors++;
                $display("FAIL %s: rst_n=%0b en=%0b expected rst_n=%0b en=%0b at %0t",
                         cur_req, rst_n, en, m_phase != 0, m_good == 3, $time);
            end
        end
    end

    task automatic check(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig(int gap);
        cyc(gap);
        trig = 0;
        cyc(1);
        trig = 1;
    endtask

    task automatic wait_release();
        for (int k = 0; k < 100 && !rst_n; k++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        check("R1", rst_n, 1'b0);
        check("R1", en, 1'b0);
        rst = 0;
        cur_req = "R7";
        cyc(PC - 1);
        check("R7", rst_n, 1'b0);
        cyc(1);
        check("R7", rst_n, 1'b1);
        // three correct triggers
        cur_req = "R4";
        pulse_trig(9); check("R4", rst_n, 1'b1); check("R5", en, 1'b0);
        pulse_trig(9); check("R5", en, 1'b0);
        cur_req = "R5";
        pulse_trig(9); check("R5", en, 1'b1);
        // early trigger
        cur_req = "R2";
        pulse_trig(3); check("R2", rst_n, 1'b0); check("R6", en, 1'b0);
        wait_release();
        // rebuild enable then time out
        cur_req = "R6";
        pulse_trig(10); pulse_trig(10); check("R6", en, 1'b0);
        pulse_trig(10); check("R6", en, 1'b1);
        cur_req = "R3";
        cyc(CW + OW + 1); check("R3", rst_n, 1'b0); check("R3", en, 1'b0);
        wait_release();
        // long period, tsel 0 and 1, timeout
        cur_req = "R8";
        mode = 1; tsel = 0;
        pulse_trig(9);
        pulse_trig(3);          // ignored in the long period
        cyc(LB - 8); check("R8", rst_n, 1'b1);
        cyc(6); check("R8", rst_n, 1'b0);
        wait_release();
        tsel = 1;
        pulse_trig(9);
        cyc(2 * LB - 6); check("R8", rst_n, 1'b1);
        cyc(6); check("R8", rst_n, 1'b0);
        wait_release();
        // return to short period via mode
        cur_req = "R9";
        tsel = 0;
        pulse_trig(9);
        cyc(5); mode = 0;
        pulse_trig(9); check("R9", rst_n, 1'b1);
        pulse_trig(9); check("R9", rst_n, 1'b1);
        // wake glitch ignored, held level resets
        cur_req = "R11";
        mode = 1;
        pulse_trig(9);
        wake[2] = 1; cyc(2); wake[2] = 0;
        cyc(6); check("R11", rst_n, 1'b1);
        cur_req = "R10";
        wake[4] = 1; cyc(DEB + 3); check("R10", rst_n, 1'b0);
        wait_release();
        mode = 0;
        wake[4] = 0; cyc(DEB + 3); check("R10", rst_n, 1'b1);
        pulse_trig(2); // early -> pulse, keeps model in step
        wait_release();
        mode = 1;
        pulse_trig(9);
        wake[0] = 1; cyc(DEB + 3); check("R10", rst_n, 1'b0);
        cyc(20);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule